// File: doc/BRIEF.md
# Isolated Link Status Supervisor

This block sits on the host side of a two-chip isolated link, one chip next to the controller and one next to the telephone line. It keeps the power-down control bit for the link and reports a small status register. That register holds the frame-detect indication, a sticky off-hook failure flag and a sticky link-error flag. Line-side status fields arrive on plain pins. They are passed on to the host only while frames are being detected. While there is no frame detect they are forced to zero and a separate valid flag is low. Frame-sync pulses toward the host serial port are held back under the same condition.

Two watchdogs run on the system clock. The first times an off-hook request. If frame detect does not appear before the deadline, the block flags the failure and forces the power-down line high for a fixed minimum time to reset the line-side chip. After that the line again follows the software bit. The second watchdog times a clock reconfiguration. If the line side does not acknowledge it within the window, a sticky link-error bit is latched. Software clears that bit by writing 1 to it.

There is no data stream through this block. Every pin is a plain control or status level or a single-cycle pulse, so there is no valid/ready handshake and no back-pressure.

Top module: `isl_supervisor`

## Requirements
- R1: After reset the control register (address 6) reads 0x10, the status register (address 12) reads 0x00 and `pdn` is 1. Any other address reads 0.
- R2: A write to address 6 stores the whole byte, which reads back unchanged. Bit 4 of that register drives `pdn` whenever no recovery pulse is active.
- R3: Status bit 6 (frame detect) is 1 exactly when `link_fdet` is 1 and `pdn` is 0.
- R4: When frame detect is 1, `ls_valid` is 1 and the ring, loop-current, chip-ID and revision outputs equal their inputs. When frame detect is 0, `ls_valid` and all of those outputs are 0.
- R5: `host_fsync` follows `link_fsync` while frame detect is 1 and stays 0 otherwise.
- R6: An `offhook_req` pulse starts a deadline of OFFHOOK_CYC cycles. If frame detect is seen before it ends, no failure is recorded. Otherwise status bit 5 is set and stays set until 1 is written to it.
- R7: An off-hook failure holds `pdn` at 1 for exactly PDN_CYC cycles. After that `pdn` follows control bit 4 again.
- R8: A `clk_chg` pulse starts a window of ACK_CYC cycles. A `clk_ack` inside the window cancels it. If the window ends without an acknowledge, status bit 7 is set.
- R9: Status bit 7 stays set until a write to address 12 with data bit 7 set. A write with that bit 0 leaves it set. A new `clk_chg` restarts the acknowledge window from its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational from `rd_addr` |
| link_fdet | input | 1 | Raw frame detect from the link receiver |
| link_fsync | input | 1 | Frame-sync pulse from the link receiver |
| offhook_req | input | 1 | Off-hook request pulse |
| clk_chg | input | 1 | Clock-reconfiguration pulse |
| clk_ack | input | 1 | Line-side acknowledge of the clock change |
| ls_ring | input | 1 | Line-side ring indication |
| ls_loop | input | LOOP_W | Line-side loop-current level |
| ls_chip_id | input | ID_W | Line-side chip identity |
| ls_rev | input | REV_W | Line-side revision |
| pdn | output | 1 | Power-down to the link, 1 = inactive |
| host_fsync | output | 1 | Gated frame sync toward the host serial port |
| ls_valid | output | 1 | Line-side fields are valid |
| ring_out | output | 1 | Gated ring indication |
| loop_out | output | LOOP_W | Gated loop-current level |
| chip_id_out | output | ID_W | Gated chip identity |
| rev_out | output | REV_W | Gated revision |

## Verification
The assertions assume that `offhook_req`, `clk_chg` and `clk_ack` are single-cycle pulses synchronous to `clk`. They also assume `link_fdet` and the line-side fields change only between clock edges. The stickiness properties further assume that status-register writes are the only way to clear a flag. The stimulus meets these conditions by changing every input on the falling edge and raising each pulse for exactly one rising edge. It then checks the timers a few cycles before and after each deadline, and counts the recovery pulse width cycle by cycle.

// File: rtl/isl_pkg.sv
package isl_pkg;
  localparam int unsigned CTRL_ADDR = 6;
  localparam int unsigned STAT_ADDR = 12;
  localparam int unsigned PD_BIT    = 4;
  localparam int unsigned OHF_BIT   = 5;
  localparam int unsigned FDT_BIT   = 6;
  localparam int unsigned ERR_BIT   = 7;
  localparam logic [7:0]  CTRL_RST  = 8'h10;
endpackage

// File: rtl/isl_deadline.sv
module isl_deadline #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic busy,
  output logic expired
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy && cancel) begin
        busy <= 1'b0;
      end else if (busy && cnt == LAST) begin
        busy    <= 1'b0;
        expired <= 1'b1;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // an expiry can only follow a running window
  a_r8_exp_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> $past(busy));
  // a cancel without a restart ends the window
  a_r6_cancel_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cancel && !start) |=> (!busy && !expired));
endmodule

// File: rtl/isl_regs.sv
module isl_regs
  import isl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              fdt,
  input  logic              set_err,
  input  logic              set_ohf,
  output logic              pd_bit,
  output logic              err_flag,
  output logic              ohf_flag
);
  logic [DATA_W-1:0] ctrl_q;
  logic wr_ctrl, wr_stat, clr_err, clr_ohf;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign wr_stat = wr_en && (wr_addr == ADDR_W'(STAT_ADDR));
  assign clr_err = wr_stat && wr_data[ERR_BIT];
  assign clr_ohf = wr_stat && wr_data[OHF_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= DATA_W'(CTRL_RST);
      err_flag <= 1'b0;
      ohf_flag <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data;
      if (set_err)      err_flag <= 1'b1;
      else if (clr_err) err_flag <= 1'b0;
      if (set_ohf)      ohf_flag <= 1'b1;
      else if (clr_ohf) ohf_flag <= 1'b0;
    end
  end

  assign pd_bit = ctrl_q[PD_BIT];

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(CTRL_ADDR)) begin
      rd_data = ctrl_q;
    end else if (rd_addr == ADDR_W'(STAT_ADDR)) begin
      rd_data[ERR_BIT] = err_flag;
      rd_data[FDT_BIT] = fdt;
      rd_data[OHF_BIT] = ohf_flag;
    end
  end

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr_err) |=> err_flag);
  a_r6_ohf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ohf_flag && !clr_ohf) |=> ohf_flag);
endmodule

// File: rtl/isl_gate.sv
module isl_gate #(
  parameter int unsigned LOOP_W = 2,
  parameter int unsigned ID_W   = 2,
  parameter int unsigned REV_W  = 4
) (
  input  logic              fdt,
  input  logic              fsync_in,
  input  logic              ring_in,
  input  logic [LOOP_W-1:0] loop_in,
  input  logic [ID_W-1:0]   id_in,
  input  logic [REV_W-1:0]  rev_in,
  output logic              fsync_out,
  output logic              valid,
  output logic              ring_out,
  output logic [LOOP_W-1:0] loop_out,
  output logic [ID_W-1:0]   id_out,
  output logic [REV_W-1:0]  rev_out
);
  always_comb begin
    valid     = fdt;
    fsync_out = fdt & fsync_in;
    ring_out  = fdt & ring_in;
    loop_out  = fdt ? loop_in : '0;
    id_out    = fdt ? id_in   : '0;
    rev_out   = fdt ? rev_in  : '0;
  end

  always_comb begin
    a_r4_zero_when_invalid: assert (valid || (loop_out == '0 && id_out == '0
                                    && rev_out == '0 && !ring_out && !fsync_out));
  end
endmodule

// File: rtl/isl_supervisor.sv
module isl_supervisor
  import isl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned LOOP_W      = 2,
  parameter int unsigned ID_W        = 2,
  parameter int unsigned REV_W       = 4,
  parameter int unsigned OFFHOOK_CYC = 500_000,
  parameter int unsigned PDN_CYC     = 50_000,
  parameter int unsigned ACK_CYC     = 4_096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              link_fdet,
  input  logic              link_fsync,
  input  logic              offhook_req,
  input  logic              clk_chg,
  input  logic              clk_ack,
  input  logic              ls_ring,
  input  logic [LOOP_W-1:0] ls_loop,
  input  logic [ID_W-1:0]   ls_chip_id,
  input  logic [REV_W-1:0]  ls_rev,
  output logic              pdn,
  output logic              host_fsync,
  output logic              ls_valid,
  output logic              ring_out,
  output logic [LOOP_W-1:0] loop_out,
  output logic [ID_W-1:0]   chip_id_out,
  output logic [REV_W-1:0]  rev_out
);
  logic fdt, pd_bit, err_flag, ohf_flag;
  logic oh_busy, oh_exp, ack_busy, ack_exp, rec_busy, rec_exp;

  assign pdn = pd_bit | rec_busy;
  assign fdt = link_fdet & ~pdn;

  isl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .fdt(fdt),
    .set_err(ack_exp), .set_ohf(oh_exp), .pd_bit(pd_bit),
    .err_flag(err_flag), .ohf_flag(ohf_flag)
  );

  isl_deadline #(.LIMIT(OFFHOOK_CYC)) u_offhook (
    .clk(clk), .rst_n(rst_n), .start(offhook_req), .cancel(fdt),
    .busy(oh_busy), .expired(oh_exp)
  );

  isl_deadline #(.LIMIT(PDN_CYC)) u_recover (
    .clk(clk), .rst_n(rst_n), .start(oh_exp), .cancel(1'b0),
    .busy(rec_busy), .expired(rec_exp)
  );

  isl_deadline #(.LIMIT(ACK_CYC)) u_clkack (
    .clk(clk), .rst_n(rst_n), .start(clk_chg), .cancel(clk_ack),
    .busy(ack_busy), .expired(ack_exp)
  );

  isl_gate #(.LOOP_W(LOOP_W), .ID_W(ID_W), .REV_W(REV_W)) u_gate (
    .fdt(fdt), .fsync_in(link_fsync), .ring_in(ls_ring), .loop_in(ls_loop),
    .id_in(ls_chip_id), .rev_in(ls_rev), .fsync_out(host_fsync),
    .valid(ls_valid), .ring_out(ring_out), .loop_out(loop_out),
    .id_out(chip_id_out), .rev_out(rev_out)
  );

  a_r7_pdn_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    rec_busy |-> pdn);
  a_r7_recovery_ends: assert property (@(posedge clk) disable iff (!rst_n)
    rec_exp |-> (pdn == pd_bit));
  a_r3_valid_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
    ls_valid |-> (link_fdet && !pdn));
  a_r5_fsync_gated: assert property (@(posedge clk) disable iff (!rst_n)
    host_fsync |-> (link_fsync && ls_valid));
  a_r8_err_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(ack_busy, 2));
  a_r6_fail_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    oh_exp |=> ohf_flag);
  a_r6_no_pending_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!oh_busy && !offhook_req) |=> !oh_exp);
endmodule

// File: tb/sim_isl_supervisor.sv
module sim_isl_supervisor;
  localparam int OH  = 40;
  localparam int PD  = 20;
  localparam int ACK = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic link_fdet = 1'b0, link_fsync = 1'b0, offhook_req = 1'b0;
  logic clk_chg = 1'b0, clk_ack = 1'b0, ls_ring = 1'b0;
  logic [1:0] ls_loop = '0, ls_chip_id = '0, loop_out, chip_id_out;
  logic [3:0] ls_rev = '0, rev_out;
  logic pdn, host_fsync, ls_valid, ring_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  isl_supervisor #(.OFFHOOK_CYC(OH), .PDN_CYC(PD), .ACK_CYC(ACK)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .link_fdet(link_fdet), .link_fsync(link_fsync), .offhook_req(offhook_req),
    .clk_chg(clk_chg), .clk_ack(clk_ack), .ls_ring(ls_ring), .ls_loop(ls_loop),
    .ls_chip_id(ls_chip_id), .ls_rev(ls_rev), .pdn(pdn), .host_fsync(host_fsync),
    .ls_valid(ls_valid), .ring_out(ring_out), .loop_out(loop_out),
    .chip_id_out(chip_id_out), .rev_out(rev_out)
  );

  // stimulus: fdet, pd, ring, loop, id, rev, fsync ; expected: valid, ring, loop, id, rev, fsync
  typedef struct packed {
    logic fdet; logic pd; logic ring; logic [1:0] loop; logic [1:0] id;
    logic [3:0] rev; logic fs;
    logic e_val; logic e_ring; logic [1:0] e_loop; logic [1:0] e_id;
    logic [3:0] e_rev; logic e_fs;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 1'b1, 2'd3, 2'd2, 4'hA, 1'b1, 1'b1, 1'b1, 2'd3, 2'd2, 4'hA, 1'b1},
    '{1'b0, 1'b0, 1'b1, 2'd3, 2'd2, 4'hA, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'h0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 2'd1, 2'd1, 4'h5, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'h0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 2'd1, 2'd3, 4'h6, 1'b0, 1'b1, 1'b0, 2'd1, 2'd3, 4'h6, 1'b0},
    '{1'b0, 1'b1, 1'b1, 2'd2, 2'd1, 4'hF, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'h0, 1'b0},
    '{1'b1, 1'b0, 1'b1, 2'd2, 2'd0, 4'h3, 1'b0, 1'b1, 1'b1, 2'd2, 2'd0, 4'h3, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_req();  @(negedge clk); offhook_req = 1'b1; @(negedge clk); offhook_req = 1'b0; endtask
  task automatic pulse_chg();  @(negedge clk); clk_chg = 1'b1;     @(negedge clk); clk_chg = 1'b0;     endtask
  task automatic pulse_ack();  @(negedge clk); clk_ack = 1'b1;     @(negedge clk); clk_ack = 1'b0;     endtask

  initial begin
    logic [7:0] d;
    int hi;
    cyc(3);
    @(negedge clk) rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    rd(4'd6, d);  chk("R1 ctrl reset", d, 8'h10);
    rd(4'd12, d); chk("R1 status reset", d, 8'h00);
    chk("R1 pdn reset", pdn, 1'b1);
    rd(4'd3, d);  chk("R1 unmapped addr", d, 8'h00);
    // R3 link held down while pdn set
    link_fdet = 1'b1; cyc(1);
    rd(4'd12, d); chk("R3 fdt masked by pdn", d, 8'h00);
    // R2 bring-up: clear power-down
    wr(4'd6, 8'hA5);
    rd(4'd6, d); chk("R2 ctrl readback", d, 8'hA5);
    chk("R2 pdn cleared", pdn, 1'b0);
    rd(4'd12, d); chk("R3 fdt set after bring-up", d, 8'h40);

    // R4/R5 vector table
    foreach (VECS[i]) begin
      wr(4'd6, VECS[i].pd ? 8'h10 : 8'h00);
      link_fdet = VECS[i].fdet; ls_ring = VECS[i].ring; ls_loop = VECS[i].loop;
      ls_chip_id = VECS[i].id; ls_rev = VECS[i].rev; link_fsync = VECS[i].fs;
      cyc(1);
      chk("R4 valid", ls_valid, VECS[i].e_val);
      chk("R4 fields", {ring_out, loop_out, chip_id_out, rev_out},
          {VECS[i].e_ring, VECS[i].e_loop, VECS[i].e_id, VECS[i].e_rev});
      chk("R5 fsync", host_fsync, VECS[i].e_fs);
      rd(4'd12, d); chk("R3 fdt bit", d[6], VECS[i].fdet & ~VECS[i].pd);
    end
    link_fsync = 1'b0;
    wr(4'd6, 8'h00);

    // R6 off-hook success
    link_fdet = 1'b0;
    pulse_req();
    cyc(10);
    link_fdet = 1'b1;
    cyc(OH + 10);
    rd(4'd12, d); chk("R6 success no fail flag", d, 8'h40);
    chk("R7 no recovery on success", pdn, 1'b0);

    // R6/R7 off-hook timeout
    link_fdet = 1'b0;
    pulse_req();
    cyc(OH - 3);
    rd(4'd12, d); chk("R6 not failed before deadline", d[5], 1'b0);
    chk("R7 pdn low before deadline", pdn, 1'b0);
    hi = 0;
    for (int i = 0; i < PD + 30; i++) begin
      @(negedge clk);
      if (pdn) hi++;
    end
    chk("R7 recovery pulse width", hi, PD);
    chk("R7 pdn released", pdn, 1'b0);
    rd(4'd12, d); chk("R6 fail flag set", d[5], 1'b1);
    wr(4'd12, 8'h00);
    rd(4'd12, d); chk("R6 flag survives zero write", d[5], 1'b1);
    wr(4'd12, 8'h20);
    rd(4'd12, d); chk("R6 flag cleared", d[5], 1'b0);

    // R8 missing acknowledge
    pulse_chg();
    cyc(ACK - 3);
    rd(4'd12, d); chk("R8 no error inside window", d[7], 1'b0);
    cyc(6);
    rd(4'd12, d); chk("R8 error after window", d[7], 1'b1);
    // R9 sticky and write-1-clear
    wr(4'd12, 8'h00);
    rd(4'd12, d); chk("R9 zero write keeps error", d[7], 1'b1);
    wr(4'd12, 8'h80);
    rd(4'd12, d); chk("R9 error cleared", d[7], 1'b0);
    // R8 acknowledged in time
    pulse_chg();
    cyc(5);
    pulse_ack();
    cyc(ACK + 5);
    rd(4'd12, d); chk("R8 ack in time no error", d[7], 1'b0);
    // R9 restart by a second change
    pulse_chg();
    cyc(ACK - 4);
    pulse_chg();
    cyc(ACK - 4);
    rd(4'd12, d); chk("R9 restart extends window", d[7], 1'b0);
    cyc(8);
    rd(4'd12, d); chk("R9 error after restarted window", d[7], 1'b1);

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule